// File: doc/BRIEF.md
# Interrupt Controller Command and Setup Front End

This block is the register-level front end of an eight-input interrupt controller of the classic programmable kind. Software reaches it through a two-address port: one address select bit, an 8-bit write bus with a write strobe, and an 8-bit read bus enabled by a read strobe. On the command address, fixed bit patterns separate the first setup word, the read and mask-mode control word, and the non-specific end-of-interrupt command. On the data address, writes feed a short setup sequence that loads the vector base and then takes one or two more words. The number of extra words depends on flags in the first setup word. Once the sequence has finished, writes to the data address load the interrupt mask.

On the request side, each of the eight inputs sets its request bit on a rising edge. The block raises a single interrupt line when an unmasked request outranks every level in service, where a lower level number means higher priority. A one-cycle acknowledge pulse moves that request into service, and a vector output gives the base with its low three bits replaced by the winning level. Special mask mode lets masked in-service levels stop blocking lower ones.

Top module: `pic_regif`

## Requirements
- R1: A synchronous reset sets the mask to 8'hFF, clears the request and in-service registers, turns special mask mode off, selects the request register for command-address reads, leaves no setup sequence running, and holds irq_out low.
- R2: A command-address write (a0=0) with data bit 4 set starts setup. It clears the mask and in-service registers, selects the request register for reads, and makes the next data-address write the vector base word.
- R3: The first data-address write after R2 stores data bits 7:3 as the vector base. The vector output is {base[7:3], level[2:0]} for the request that wins.
- R4: In the first setup word, bit 1 = 0 means a third word follows the base word, and bit 0 = 1 means a fourth word follows. Each expected word takes one data-address write, leaves the mask unchanged, and the sequence ends after the last one.
- R5: A data-address write (a0=1) with no setup sequence running loads all 8 bits of the mask register.
- R6: A command-address write with bit 4 clear and bit 3 set is a control word. If its bit 1 is set, its bit 0 picks what command-address reads return: the in-service register (1) or the request register (0). If its bit 1 is clear, the selection is kept.
- R7: In that control word, bit 6 = 1 loads special mask mode from bit 5. Bit 6 = 0 leaves the mode unchanged.
- R8: A command-address write whose data ANDed with 8'hB8 equals 8'h20 clears the lowest-numbered set in-service bit. With no bit set it changes nothing.
- R9: A 0-to-1 transition on irq_in[n] sets request bit n. An input held high sets it only once.
- R10: irq_out is high exactly when the lowest-numbered unmasked request has a lower number than every in-service level.
- R11: In special mask mode, in-service levels that are masked do not block lower-priority requests.
- R12: An ack pulse while irq_out is high sets the winning level's in-service bit and clears its request bit. An ack while irq_out is low has no effect.
- R13: When rd is high, a data-address read returns the mask and a command-address read returns the register picked by R6. When rd is low, rdata is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a0 | input | 1 | Register select: 0 command address, 1 data address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, enables rdata |
| irq_in | input | 8 | Interrupt request inputs, rising-edge sensitive |
| ack | input | 1 | Acknowledge pulse from the processor side |
| irq_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector of the winning request |
| rdata | output | 8 | Read data |

## Verification
The hardest condition to reach is special mask mode actually unblocking a request. It needs three things at once: a level already in service, a lower-priority request pending behind it, and the in-service level masked afterwards. The stimulus acknowledges level 1, raises level 4, and confirms that masking level 1 alone does not release level 4. Only then does it turn the mode on, and it later toggles the mode with a control word that leaves the mode bit alone. The setup sequence lengths are checked by reading the mask after every setup word, so a word that is skipped or consumed by mistake shows up as a mask change.

// File: rtl/pic_regif.sv
`timescale 1ns/1ps
module pic_regif (
  input  logic       clk,
  input  logic       rst,
  input  logic       a0,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] irq_in,
  input  logic       ack,
  output logic       irq_out,
  output logic [7:0] vector,
  output logic [7:0] rdata
);
  localparam logic [1:0] SEQ_IDLE = 2'd0, SEQ_BASE = 2'd1, SEQ_W3 = 2'd2, SEQ_W4 = 2'd3;

  logic [1:0] seq;
  logic       want3, want4, rsel, smm;
  logic [7:0] imr, isr, irr, lvl_prev;
  logic [4:0] base_hi;

  function automatic logic [3:0] lowest(input logic [7:0] v);
    lowest = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[i]) lowest = 4'(i);
  endfunction

  wire cmd_wr = wr & ~a0;
  wire icw1   = cmd_wr & wdata[4];
  wire ocw3   = cmd_wr & ~wdata[4] & wdata[3];
  wire eoi    = cmd_wr & ((wdata & 8'hB8) == 8'h20);
  wire dat_wr = wr & a0;

  wire [7:0] pend = irr & ~imr;
  wire [7:0] blk  = smm ? (isr & ~imr) : isr;
  wire [3:0] p    = lowest(pend);
  wire [3:0] q    = lowest(blk);
  wire [3:0] e    = lowest(isr);

  assign irq_out = p < q;
  assign vector  = {base_hi, p[2:0]};
  assign rdata   = !rd ? 8'h00 : a0 ? imr : (rsel ? isr : irr);

  wire       grant    = ack & irq_out;
  wire [7:0] gnt_mask = grant ? (8'b1 << p[2:0]) : 8'h00;
  wire [7:0] eoi_mask = (eoi && !e[3]) ? (8'b1 << e[2:0]) : 8'h00;
  wire [7:0] rise     = irq_in & ~lvl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq <= SEQ_IDLE; want3 <= 1'b0; want4 <= 1'b0;
      imr <= 8'hFF; isr <= 8'h00; irr <= 8'h00; lvl_prev <= 8'h00;
      base_hi <= 5'd0; rsel <= 1'b0; smm <= 1'b0;
    end else begin
      lvl_prev <= irq_in;
      irr <= (irr & ~gnt_mask) | rise;
      if (icw1) begin
        isr   <= 8'h00;
        imr   <= 8'h00;
        rsel  <= 1'b0;
        want3 <= ~wdata[1];
        want4 <= wdata[0];
        seq   <= SEQ_BASE;
      end else begin
        isr <= (isr | gnt_mask) & ~eoi_mask;
        if (ocw3) begin
          if (wdata[1]) rsel <= wdata[0];
          if (wdata[6]) smm  <= wdata[5];
        end
        if (dat_wr) begin
          case (seq)
            SEQ_IDLE: imr <= wdata;
            SEQ_BASE: begin
              base_hi <= wdata[7:3];
              seq <= want3 ? SEQ_W3 : (want4 ? SEQ_W4 : SEQ_IDLE);
            end
            SEQ_W3:  seq <= want4 ? SEQ_W4 : SEQ_IDLE;
            default: seq <= SEQ_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pic_regif_chk.sv
`timescale 1ns/1ps
module pic_regif_chk (
  input logic       clk,
  input logic       rst,
  input logic       a0,
  input logic [7:0] wdata,
  input logic       wr,
  input logic       ack,
  input logic       irq_out,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic [7:0] irr,
  input logic [1:0] seq
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (imr == 8'hFF && isr == 8'h00 && irr == 8'h00 && seq == 2'd0 && !irq_out));

  assert_setup_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && !a0 && wdata[4]) |=> (imr == 8'h00 && isr == 8'h00 && seq == 2'd1));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && a0 && seq == 2'd0) |=> imr == $past(wdata));

  assert_setup_keeps_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && a0 && seq != 2'd0) |=> $stable(imr));

  assert_eoi_one_bit_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && !a0 && (wdata & 8'hB8) == 8'h20 && !ack && isr != 8'h00)
      |=> $countones(isr) == $countones($past(isr)) - 1);

  assert_irq_needs_request_R10: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (irr & ~imr) != 8'h00);

  assert_grant_moves_R12: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_out && !wr) |=> ($countones(isr) == $countones($past(isr)) + 1));

  assert_no_grant_R12: assert property (@(posedge clk) disable iff (rst)
    (ack && !irq_out && !wr) |=> $stable(isr));
endmodule

bind pic_regif pic_regif_chk u_chk (
  .clk(clk), .rst(rst), .a0(a0), .wdata(wdata), .wr(wr), .ack(ack),
  .irq_out(irq_out), .imr(imr), .isr(isr), .irr(irr), .seq(seq)
);

// File: tb/test_pic_regif.sv
`timescale 1ns/1ps
module test_pic_regif;
  logic clk = 0, rst = 1, a0 = 0, wr = 0, rd = 0, ack = 0;
  logic [7:0] wdata = 0, irq_in = 0;
  logic irq_out;
  logic [7:0] vector, rdata;
  int errors = 0, checks = 0;

  pic_regif i_pic_regif (
    .clk(clk), .rst(rst), .a0(a0), .wdata(wdata), .wr(wr), .rd(rd),
    .irq_in(irq_in), .ack(ack), .irq_out(irq_out), .vector(vector), .rdata(rdata)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); a0 = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0; a0 = 0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] v);
    @(negedge clk); a0 = a; rd = 1; #1 v = rdata; rd = 0; a0 = 0;
  endtask

  task automatic raise(input int lvl);
    @(negedge clk); irq_in[lvl] = 1;
    @(negedge clk);
  endtask

  task automatic drop(input int lvl);
    @(negedge clk); irq_in[lvl] = 0;
    @(negedge clk);
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_reg(1, v); chk("R1 mask after reset", v, 8'hFF);
    rd_reg(0, v); chk("R1 request reg after reset", v, 8'h00);
    chk("R1 irq_out low", {7'd0, irq_out}, 8'h00);
    @(negedge clk); a0 = 1; rd = 0; #1 chk("R13 rdata zero without rd", rdata, 8'h00); a0 = 0;
  endtask

  task automatic t_setup_lengths;
    logic [7:0] v;
    wr_reg(0, 8'h13);
    rd_reg(1, v); chk("R2 setup clears mask", v, 8'h00);
    wr_reg(1, 8'h48);
    wr_reg(1, 8'h01);
    rd_reg(1, v); chk("R4 single+w4 keeps mask", v, 8'h00);
    wr_reg(1, 8'h0F);
    rd_reg(1, v); chk("R5 mask load after single+w4", v, 8'h0F);
    wr_reg(0, 8'h11);
    wr_reg(1, 8'h48); wr_reg(1, 8'hAA);
    rd_reg(1, v); chk("R4 cascade w3 keeps mask", v, 8'h00);
    wr_reg(1, 8'h55);
    rd_reg(1, v); chk("R4 cascade w4 keeps mask", v, 8'h00);
    wr_reg(1, 8'h33);
    rd_reg(1, v); chk("R5 mask after cascade+w4", v, 8'h33);
    wr_reg(0, 8'h12);
    wr_reg(1, 8'h48); wr_reg(1, 8'h5A);
    rd_reg(1, v); chk("R4 single no w4 ends after base", v, 8'h5A);
    wr_reg(0, 8'h10);
    wr_reg(1, 8'h48); wr_reg(1, 8'h77);
    rd_reg(1, v); chk("R4 cascade no w4 w3 keeps mask", v, 8'h00);
    wr_reg(1, 8'hC3);
    rd_reg(1, v); chk("R4 cascade no w4 then mask", v, 8'hC3);
    wr_reg(0, 8'h13); wr_reg(1, 8'h45); wr_reg(1, 8'h01); wr_reg(1, 8'h00);
  endtask

  task automatic t_request_ack;
    logic [7:0] v;
    raise(3);
    chk("R10 irq_out on request", {7'd0, irq_out}, 8'h01);
    chk("R3 vector level 3", vector, 8'h43);
    rd_reg(0, v); chk("R9 request bit set", v, 8'h08);
    pulse_ack;
    chk("R12 irq_out drops after grant", {7'd0, irq_out}, 8'h00);
    wr_reg(0, 8'h0B);
    rd_reg(0, v); chk("R12 in-service after grant", v, 8'h08);
    wr_reg(0, 8'h08);
    rd_reg(0, v); chk("R6 selection kept when bit1 clear", v, 8'h08);
    wr_reg(0, 8'h0A);
    rd_reg(0, v); chk("R9 held input no new request", v, 8'h00);
    drop(3);
  endtask

  task automatic t_priority_eoi;
    logic [7:0] v;
    raise(5);
    chk("R10 level 5 blocked by 3", {7'd0, irq_out}, 8'h00);
    raise(1);
    chk("R10 level 1 outranks 3", {7'd0, irq_out}, 8'h01);
    chk("R3 vector level 1", vector, 8'h41);
    pulse_ack;
    wr_reg(0, 8'h0B);
    rd_reg(0, v); chk("R12 two in service", v, 8'h0A);
    wr_reg(0, 8'h20);
    rd_reg(0, v); chk("R8 lowest in-service cleared", v, 8'h08);
    chk("R10 still blocked by 3", {7'd0, irq_out}, 8'h00);
    wr_reg(0, 8'h20);
    chk("R10 level 5 released", {7'd0, irq_out}, 8'h01);
    chk("R3 vector level 5", vector, 8'h45);
    pulse_ack;
    wr_reg(0, 8'h20);
    wr_reg(0, 8'h20);
    rd_reg(0, v); chk("R8 EOI on empty is no-op", v, 8'h00);
    pulse_ack;
    rd_reg(0, v); chk("R12 ack without irq no effect", v, 8'h00);
    drop(1); drop(5);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr_reg(1, 8'h04);
    raise(2);
    chk("R10 masked request no irq", {7'd0, irq_out}, 8'h00);
    wr_reg(0, 8'h0A);
    rd_reg(0, v); chk("R9 masked request recorded", v, 8'h04);
    wr_reg(1, 8'h00);
    chk("R10 unmask raises irq", {7'd0, irq_out}, 8'h01);
    pulse_ack; wr_reg(0, 8'h20); drop(2);
  endtask

  task automatic t_special_mask;
    raise(1); pulse_ack;
    raise(4);
    chk("R10 level 4 blocked by 1", {7'd0, irq_out}, 8'h00);
    wr_reg(1, 8'h02);
    chk("R11 mask alone does not release", {7'd0, irq_out}, 8'h00);
    wr_reg(0, 8'h68);
    chk("R11 special mask releases level 4", {7'd0, irq_out}, 8'h01);
    chk("R11 vector level 4", vector, 8'h44);
    wr_reg(0, 8'h28);
    chk("R7 bit6 clear keeps mode", {7'd0, irq_out}, 8'h01);
    wr_reg(0, 8'h48);
    chk("R7 mode turned off", {7'd0, irq_out}, 8'h00);
  endtask

  task automatic t_setup_resets;
    logic [7:0] v;
    wr_reg(0, 8'h0B);
    wr_reg(0, 8'h13);
    rd_reg(0, v); chk("R2 read select back to requests", v, 8'h10);
    wr_reg(0, 8'h0B);
    rd_reg(0, v); chk("R2 in-service cleared", v, 8'h00);
    wr_reg(1, 8'hA8); wr_reg(1, 8'h01);
    chk("R3 new base in vector", vector, 8'hAC);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_setup_lengths;
    t_request_ack;
    t_priority_eoi;
    t_mask;
    t_special_mask;
    t_setup_resets;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule